// File: doc/BRIEF.md
# UART Interrupt Identification Register

This block turns the pending interrupt flags of a 16550-style serial port into the 8-bit identification value that the host reads. It picks the most urgent pending source and writes its code into the low bits. Bit 0 tells the host whether anything is pending at all. When the FIFOs are enabled, the two top bits are set so that software can detect FIFO mode.

A host read is signalled by a strobe that stays high for the whole access. The value seen on the first cycle of the strobe is captured, and the output holds that value until the strobe drops. Sources that arrive during the access therefore cannot change the value in the middle of the read. Once the strobe is low, the output follows the live sources again with no delay.

The block does not generate sources, mask them by enable, or clear them. It only encodes the flags it receives.

Top module: `uart_iid_reg`

## Requirements
- R1: With no effective source pending, bit 0 is 1 and bits 3:1 are 000, so the output reads 0x01, or 0xC1 in FIFO mode.
- R2: Line status has the highest priority: whenever it is pending, bits 3:0 read 0110, whatever other flags are set.
- R3: If line status is absent and data ready is pending, bits 3:0 read 0100. Data ready wins over the timeout, transmit-empty and modem flags.
- R4: In FIFO mode, if the timeout is the most urgent pending source, bits 3:0 read 1100. The timeout shares priority level two with data ready and yields to it.
- R5: If transmit holding empty is the most urgent pending source, bits 3:0 read 0010. It wins over the modem flag.
- R6: If modem status is the only pending source, bits 3:0 read 0000.
- R7: Bits 5:4 always read 0.
- R8: Outside a held read, bits 7:6 are both 1 when FIFO mode is enabled and both 0 when it is not.
- R9: In non-FIFO mode bit 3 is 0 and the timeout flag is ignored. With only the timeout set, the output reads 0x01.
- R10: On every cycle of a read strobe, the output equals the value shown on the strobe's first cycle, even if the source or FIFO-mode flags change during the access.
- R11: In the first cycle after the strobe falls, the output again reflects the live inputs. A new strobe that rises after at least one low cycle captures afresh.
- R12: After reset, the first cycle of a read strobe shows the live value; no earlier read history carries over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enabled |
| rls_i | input | 1 | Receiver line status pending |
| rda_i | input | 1 | Received data ready / trigger level reached |
| cto_i | input | 1 | Receive character timeout pending |
| thre_i | input | 1 | Transmitter holding register empty pending |
| msr_i | input | 1 | Modem status change pending |
| rd_i | input | 1 | Host read strobe for the identification register, high for the whole access |
| iid_o | output | 8 | Identification value |

## Verification
Each source is first driven on its own, in both FIFO and non-FIFO mode. This separates the per-source codes from the mode bits, and shows that a lone timeout is ignored outside FIFO mode. Pairs and full sets of flags are then driven together to confirm each priority boundary, including the tie between data ready and timeout. Read strobes of different lengths are run while sources and the mode flag change underneath them. These cases separate a true hold from a value that is re-sampled, and show when the hold is released. A long stretch of random flags and random strobes, checked every clock against a behavioural model, covers back-to-back reads and a strobe that starts right after reset.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  localparam int unsigned IID_W  = 8;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_MSR  = 3'b000,
    CODE_THRE = 3'b001,
    CODE_RDA  = 3'b010,
    CODE_RLS  = 3'b011,
    CODE_CTO  = 3'b110
  } iid_code_e;

  typedef struct packed {
    logic rls;
    logic rda;
    logic cto;
    logic thre;
    logic msr;
  } iid_src_t;
endpackage

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_iid_pkg::*;
(
  input  iid_src_t         src_i,
  input  logic             fifo_en_i,
  output logic             pend_o,
  output logic [CODE_W-1:0] code_o
);
  logic cto_eff;
  assign cto_eff = src_i.cto & fifo_en_i;  // timeout only exists with FIFOs on

  always_comb begin
    pend_o = 1'b1;
    code_o = CODE_MSR;
    if (src_i.rls)       code_o = CODE_RLS;
    else if (src_i.rda)  code_o = CODE_RDA;
    else if (cto_eff)    code_o = CODE_CTO;
    else if (src_i.thre) code_o = CODE_THRE;
    else if (src_i.msr)  code_o = CODE_MSR;
    else                 pend_o = 1'b0;
  end
endmodule

// File: rtl/uart_iid_hold.sv
module uart_iid_hold
  import uart_iid_pkg::*;
#(
  parameter int unsigned W = IID_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] val_o
);
  logic         rd_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      rd_q <= rd_i;
      if (rd_i && !rd_q) hold_q <= live_i;
    end
  end

  // first strobe cycle passes live value, which is what gets captured
  assign val_o = (rd_i && rd_q) ? hold_q : live_i;
endmodule

// File: rtl/uart_iid_reg.sv
module uart_iid_reg
  import uart_iid_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             rls_i,
  input  logic             rda_i,
  input  logic             cto_i,
  input  logic             thre_i,
  input  logic             msr_i,
  input  logic             rd_i,
  output logic [IID_W-1:0] iid_o
);
  localparam int unsigned MODE_W = IID_W - CODE_W - 3;

  iid_src_t          src;
  logic              pend;
  logic [CODE_W-1:0] code;
  logic [IID_W-1:0]  live;

  assign src = '{rls: rls_i, rda: rda_i, cto: cto_i, thre: thre_i, msr: msr_i};

  uart_iid_prio u_prio (
    .src_i    (src),
    .fifo_en_i(fifo_en_i),
    .pend_o   (pend),
    .code_o   (code)
  );

  assign live = {{MODE_W{fifo_en_i}}, 2'b00, code, ~pend};

  uart_iid_hold #(.W(IID_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rd_i  (rd_i),
    .live_i(live),
    .val_o (iid_o)
  );
endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fifo_en_i,
  input logic       rls_i,
  input logic       rda_i,
  input logic       cto_i,
  input logic       thre_i,
  input logic       msr_i,
  input logic       rd_i,
  input logic [7:0] iid_o
);
  p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o[5:4] == 2'b00);

  p_mode_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> iid_o[7:6] == {2{fifo_en_i}});

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !rls_i && !rda_i && !thre_i && !msr_i && !(cto_i && fifo_en_i))
      |-> iid_o[3:0] == 4'b0001);

  p_line_stat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && rls_i) |-> iid_o[3:0] == 4'b0110);

  p_no_to_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !fifo_en_i) |-> !iid_o[3]);

  p_read_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $past(rd_i)) |-> $stable(iid_o));
endmodule

bind uart_iid_reg uart_iid_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fifo_en_i(fifo_en_i),
  .rls_i    (rls_i),
  .rda_i    (rda_i),
  .cto_i    (cto_i),
  .thre_i   (thre_i),
  .msr_i    (msr_i),
  .rd_i     (rd_i),
  .iid_o    (iid_o)
);

// File: tb/uart_iid_reg_test.sv
module uart_iid_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, rls = 1'b0, rda = 1'b0, cto = 1'b0;
  logic       thre = 1'b0, msr = 1'b0, rd = 1'b0;
  logic [7:0] iid;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R12";

  always #2 clk = ~clk;  // 250 MHz

  uart_iid_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .rls_i(rls),
    .rda_i(rda), .cto_i(cto), .thre_i(thre), .msr_i(msr), .rd_i(rd),
    .iid_o(iid)
  );

  // behavioural reference
  function automatic logic [7:0] live_ref();
    logic [7:0] v;
    v = fifo_en ? 8'hC0 : 8'h00;
    if (rls)                 v = v | 8'h06;
    else if (rda)            v = v | 8'h04;
    else if (cto && fifo_en) v = v | 8'h0C;
    else if (thre)           v = v | 8'h02;
    else if (msr)            v = v | 8'h00;
    else                     v = v | 8'h01;
    return v;
  endfunction

  bit         in_read = 1'b0;
  logic [7:0] frozen = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_read <= 1'b0;
      frozen  <= 8'h00;
    end else begin
      if (rd && !in_read) frozen <= live_ref();
      in_read <= rd;
    end
  end

  function automatic logic [7:0] exp_ref();
    return (rd && in_read) ? frozen : live_ref();
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic [7:0] e;
    e = exp_ref();
    total++;
    if (iid !== e) begin
      bad++;
      $display("FAIL %s: iid actual=%h expected=%h", cur_req, iid, e);
    end
  end

  task automatic directed(input string req, input logic [7:0] exp);
    @(negedge clk);
    #0.5;
    total++;
    if (iid !== exp) begin
      bad++;
      $display("FAIL %s: iid actual=%h expected=%h", req, iid, exp);
    end
  endtask

  task automatic set_src(input logic f, input logic a, input logic b,
                         input logic c, input logic d, input logic m);
    @(posedge clk);
    #1;
    fifo_en = f; rls = a; rda = b; cto = c; thre = d; msr = m;
  endtask

  task automatic set_rd(input logic v);
    @(posedge clk);
    #1;
    rd = v;
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_req = "R12";
    directed("R12", 8'h01);  // reset state, nothing pending
    #3 rst_n = 1'b1;
    // R12: read strobe right after reset with a source up
    set_src(1, 0, 0, 0, 1, 0);
    set_rd(1);
    directed("R12", 8'hC2);
    set_src(1, 1, 0, 0, 0, 0);
    directed("R10", 8'hC2);
    set_rd(0);
    directed("R11", 8'hC6);

    for (int f = 0; f < 2; f++) begin
      cur_req = "R1";
      set_src(f[0], 0, 0, 0, 0, 0); directed("R1", f[0] ? 8'hC1 : 8'h01);
      cur_req = "R2";
      set_src(f[0], 1, 1, 1, 1, 1); directed("R2", f[0] ? 8'hC6 : 8'h06);
      cur_req = "R3";
      set_src(f[0], 0, 1, 1, 1, 1); directed("R3", f[0] ? 8'hC4 : 8'h04);
      cur_req = "R4";
      set_src(f[0], 0, 0, 1, 1, 1); directed(f[0] ? "R4" : "R9", f[0] ? 8'hCC : 8'h02);
      cur_req = "R5";
      set_src(f[0], 0, 0, 0, 1, 1); directed("R5", f[0] ? 8'hC2 : 8'h02);
      cur_req = "R6";
      set_src(f[0], 0, 0, 0, 0, 1); directed("R6", f[0] ? 8'hC0 : 8'h00);
      cur_req = "R9";
      set_src(f[0], 0, 0, 1, 0, 0); directed(f[0] ? "R4" : "R9", f[0] ? 8'hCC : 8'h01);
    end

    // R10: freeze across source and mode change, then release
    cur_req = "R10";
    set_src(0, 0, 0, 0, 0, 1);
    set_rd(1);
    directed("R10", 8'h00);
    set_src(1, 1, 0, 0, 0, 0);
    directed("R10", 8'h00);
    set_src(1, 0, 1, 0, 0, 0);
    directed("R10", 8'h00);
    set_rd(0);
    cur_req = "R11";
    directed("R11", 8'hC4);
    set_rd(1);
    directed("R11", 8'hC4);
    set_src(0, 0, 0, 0, 0, 0);
    directed("R10", 8'hC4);
    set_rd(0);
    directed("R11", 8'h01);

    // random flags and strobes
    cur_req = "R10";
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      #1;
      {fifo_en, rls, rda, cto, thre, msr} = 6'($urandom);
      if (($urandom % 4) == 0) rd = ~rd;
    end
    rd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule